// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the time of day and the calendar date in packed BCD. It has seven fields: seconds, minutes, hours, day of week, date, month and two-digit year. A divider counts enable pulses from a 32.768 kHz source. It produces one internal second tick for every `DIV` of those pulses, and from the same count it makes a 1 Hz square wave. On each tick the fields advance with a full carry chain. The chain handles months of 28, 29, 30 and 31 days, and it treats a year divisible by four as a leap year, which is correct for 2000 to 2099. Hours can run in a 24-hour format or in a 12-hour format with an afternoon flag. Bit 6 of the hours field chooses between them.

Software loads any field through a single-cycle write strobe. Writing the seconds field also clears the divider, so the next second begins at a known instant. Reads do not come from the live counters. A one-cycle read-start pulse copies all seven fields into a user copy, and the read address then selects a byte from that copy combinationally. A multi-byte read therefore sees one consistent instant while timekeeping goes on underneath. Both ports are register-style strobes that are always accepted. There is no back-pressure: a write takes effect at the clock edge that samples it, and a read-start replaces the copy at that edge.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, addresses 0..6 read 00, 00, 00, 01, 01, 01, 00 (seconds, minutes, hours, day of week, date, month, year), and `one_hz_out` is 1.
- R2: Seconds and minutes count 00..59 in BCD. Seconds passing 59 go to 00 and increment minutes. Minutes passing 59 go to 00 and increment hours.
- R3: With hours bit 6 = 0 (24-hour format), hours count 00..23 in BCD, with bit 5 as the upper tens bit. Passing 23 gives 00 and advances the day.
- R4: With hours bit 6 = 1 (12-hour format), bits 4:0 hold 01..12 in BCD and bit 5 is the afternoon flag (1 = PM). The sequence is 12, 01 .. 11, and the flag toggles when 11 becomes 12. The day advances only when 11 PM becomes 12 AM.
- R5: On a day advance the date goes to 01 after the last day of the month. The last day is 30 for months 04, 06, 09 and 11, 31 for the other months except February, and 29 or 28 for February as the binary value of the BCD year is or is not divisible by 4. Month 12 goes to 01 and increments the year, and year 99 goes to 00.
- R6: On a day advance the day of week counts 1..7, and 7 goes to 1.
- R7: A write stores `wr_data` into the field at `wr_addr` (0 sec, 1 min, 2 hours, 3 day of week, 4 date, 5 month, 6 year) ANDed with a field mask: 7F, 7F, 7F, 07, 3F, 1F and FF. Masked-off bits read 0.
- R8: A write to address 0 clears the divider. The next second tick comes exactly `DIV` oscillator pulses after that write.
- R9: A second tick occurs on every `DIV`-th oscillator pulse. `one_hz_out` is 1 while the divider count is below `DIV/2` and 0 for the rest of the period.
- R10: A `rd_start` pulse copies all fields into the user copy at that edge. `rd_data` shows the byte at `rd_addr` from that copy and stays unchanged while the live time advances, until the next `rd_start`. Address 7 reads 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable per 32.768 kHz period |
| wr_en | input | 1 | Write strobe, always accepted |
| wr_addr | input | 3 | Field address for the write |
| wr_data | input | 8 | BCD data to write |
| rd_start | input | 1 | Start of a read: take the user copy |
| rd_addr | input | 3 | Field address for the read |
| rd_data | output | 8 | Selected byte of the user copy |
| one_hz_out | output | 1 | 1 Hz square wave |

## Verification
The assertions assume that every written value is a legal BCD value for its field and format. The seconds range check and the date range check depend on that, because a write can plant any masked byte. They also assume that `DIV` is at least 2, so a seconds write can never coincide with a tick. The stimulus only writes legal times, except in the masking test. That test leaves bit patterns that stay legal for the fields under assertion. `osc_tick` is held low while several fields are being loaded, so no carry can fall between two writes.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam logic [2:0] A_SEC  = 3'd0;
  localparam logic [2:0] A_MIN  = 3'd1;
  localparam logic [2:0] A_HOUR = 3'd2;
  localparam logic [2:0] A_DOW  = 3'd3;
  localparam logic [2:0] A_DATE = 3'd4;
  localparam logic [2:0] A_MON  = 3'd5;
  localparam logic [2:0] A_YEAR = 3'd6;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{year: 8'h00, mon: 8'h01, date: 8'h01,
                                 dow: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  function automatic logic [7:0] field_mask(input logic [2:0] a);
    case (a)
      A_SEC, A_MIN, A_HOUR: return 8'h7F;
      A_DOW:                return 8'h07;
      A_DATE:               return 8'h3F;
      A_MON:                return 8'h1F;
      A_YEAR:               return 8'hFF;
      default:              return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] year);
    logic [7:0] ybin;
    ybin = ({4'd0, year[7:4]} * 8'd10) + {4'd0, year[3:0]};
    if (mon == 8'h02)
      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
    else if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11)
      return 8'h30;
    else
      return 8'h31;
  endfunction
endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic restart,
  output logic sec_tick,
  output logic sq_out
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt;
  logic          at_top;

  assign at_top = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (osc_tick)     cnt <= at_top ? '0 : cnt + 1'b1;
  end

  assign sec_tick = osc_tick && at_top && !restart;
  assign sq_out   = (cnt < CW'(HALF));
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import bcd_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output cal_t       live
);
  cal_t       q, n;
  logic       c_min, c_hour, c_day, c_mon, c_year;
  logic [7:0] inc24, inc12, wval;
  logic       pm;

  always_comb begin
    n      = q;
    c_min  = 1'b0;
    c_hour = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_year = 1'b0;
    pm     = q.hour[5];
    inc24  = bcd_inc({2'b00, q.hour[5:0]});
    inc12  = bcd_inc({3'b000, q.hour[4:0]});
    wval   = wr_data & field_mask(wr_addr);

    if (sec_tick) begin
      if (q.sec == 8'h59) begin n.sec = 8'h00; c_min = 1'b1; end
      else n.sec = bcd_inc(q.sec);
    end
    if (c_min) begin
      if (q.min == 8'h59) begin n.min = 8'h00; c_hour = 1'b1; end
      else n.min = bcd_inc(q.min);
    end
    if (c_hour) begin
      if (!q.hour[6]) begin
        if (q.hour[5:0] == 6'h23) begin n.hour = 8'h00; c_day = 1'b1; end
        else n.hour = inc24 & 8'h3F;
      end else begin
        if (q.hour[4:0] == 5'h11) begin
          n.hour = {2'b01, ~pm, 5'h12};
          c_day  = pm;
        end else if (q.hour[4:0] == 5'h12) begin
          n.hour = {2'b01, pm, 5'h01};
        end else begin
          n.hour = {2'b01, pm, 5'h00} | (inc12 & 8'h1F);
        end
      end
    end
    if (c_day) begin
      n.dow = (q.dow == 8'h07) ? 8'h01 : q.dow + 8'd1;
      if (q.date == last_date(q.mon, q.year)) begin n.date = 8'h01; c_mon = 1'b1; end
      else n.date = bcd_inc(q.date);
    end
    if (c_mon) begin
      if (q.mon == 8'h12) begin n.mon = 8'h01; c_year = 1'b1; end
      else n.mon = bcd_inc(q.mon);
    end
    if (c_year) n.year = (q.year == 8'h99) ? 8'h00 : bcd_inc(q.year);

    if (wr_en) begin
      case (wr_addr)
        A_SEC:   n.sec  = wval;
        A_MIN:   n.min  = wval;
        A_HOUR:  n.hour = wval;
        A_DOW:   n.dow  = wval;
        A_DATE:  n.date = wval;
        A_MON:   n.mon  = wval;
        A_YEAR:  n.year = wval;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= CAL_RESET;
    else        q <= n;
  end

  assign live = q;
endmodule

// File: rtl/cal_snapshot.sv
module cal_snapshot
  import bcd_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_start,
  input  cal_t       live,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  cal_t snap;

  always_ff @(posedge clk) begin
    if (!rst_n)        snap <= CAL_RESET;
    else if (rd_start) snap <= live;
  end

  always_comb begin
    case (rd_addr)
      A_SEC:   rd_data = snap.sec;
      A_MIN:   rd_data = snap.min;
      A_HOUR:  rd_data = snap.hour;
      A_DOW:   rd_data = snap.dow;
      A_DATE:  rd_data = snap.date;
      A_MON:   rd_data = snap.mon;
      A_YEAR:  rd_data = snap.year;
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_start,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       one_hz_out
);
  logic sec_tick;
  logic sec_wr;
  cal_t live;

  assign sec_wr = wr_en && (wr_addr == A_SEC);

  cal_divider #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .restart(sec_wr),
    .sec_tick(sec_tick), .sq_out(one_hz_out)
  );

  cal_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .live(live)
  );

  cal_snapshot u_snap (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .live(live),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       rd_start,
  input logic [2:0] rd_addr,
  input logic [7:0] rd_data,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] date_q
);
  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[3:0] <= 4'd9) && (sec_q <= 8'h59));

  // R5
  date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (date_q != 8'h00) && (date_q <= 8'h31));

  // R8
  restart_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> !sec_tick);

  // R9
  tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_en) |=> (sec_q != $past(sec_q)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(date_q)));

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> (!$stable(rd_addr) || $stable(rd_data)));
endmodule

bind bcd_calendar cal_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
  .wr_addr(wr_addr), .rd_start(rd_start), .rd_addr(rd_addr), .rd_data(rd_data),
  .sec_q(live.sec), .min_q(live.min), .date_q(live.date)
);

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_start = 1'b0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic       one_hz_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  bcd_calendar #(.DIV(DIV)) u_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_start(rd_start),
    .rd_addr(rd_addr), .rd_data(rd_data), .one_hz_out(one_hz_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int month_len(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] enc12(input int h24);
    int h;
    h = h24 % 12;
    if (h == 0) h = 12;
    return 8'h40 | ((h24 >= 12) ? 8'h20 : 8'h00) | bcd(h);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_start = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_start = 1'b0;
    d = rd_data;
  endtask

  task automatic osc(input int cycles);
    @(negedge clk);
    osc_tick = 1'b1;
    repeat (cycles) @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                         input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                         input logic [7:0] y);
    wr(3'd1, mi); wr(3'd2, h); wr(3'd3, dw); wr(3'd4, dt);
    wr(3'd5, mo); wr(3'd6, y); wr(3'd0, s);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int yrs[4];
    yrs[0] = 23; yrs[1] = 24; yrs[2] = 0; yrs[3] = 99;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 one_hz_out", {7'd0, one_hz_out}, 8'h01);
    rd(3'd0, d); check("R1 sec", d, 8'h00);
    rd(3'd1, d); check("R1 min", d, 8'h00);
    rd(3'd2, d); check("R1 hour", d, 8'h00);
    rd(3'd3, d); check("R1 dow", d, 8'h01);
    rd(3'd4, d); check("R1 date", d, 8'h01);
    rd(3'd5, d); check("R1 month", d, 8'h01);
    rd(3'd6, d); check("R1 year", d, 8'h00);

    // R2 seconds and minutes through two minute carries
    set_all(8'h00, 8'h58, 8'h10, 8'h02, 8'h15, 8'h06, 8'h24);
    for (int i = 1; i <= 120; i++) begin
      osc(DIV);
      rd(3'd0, d); check("R2 sec", d, bcd(i % 60));
      rd(3'd1, d); check("R2 min", d, bcd((58 + i / 60) % 60));
    end
    rd(3'd2, d); check("R2 hour carry", d, 8'h11);

    // R3 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      set_all(8'h59, 8'h59, bcd(h), 8'h03, 8'h10, 8'h05, 8'h24);
      osc(DIV);
      rd(3'd2, d); check("R3 hour", d, bcd((h + 1) % 24));
      rd(3'd4, d); check("R3 day carry", d, (h == 23) ? 8'h11 : 8'h10);
    end

    // R4 12-hour sweep
    for (int h = 0; h < 24; h++) begin
      set_all(8'h59, 8'h59, enc12(h), 8'h03, 8'h10, 8'h05, 8'h24);
      osc(DIV);
      rd(3'd2, d); check("R4 hour", d, enc12((h + 1) % 24));
      rd(3'd4, d); check("R4 day carry", d, (h == 23) ? 8'h11 : 8'h10);
    end

    // R6 day of week wrap
    for (int w = 1; w <= 7; w++) begin
      set_all(8'h59, 8'h59, 8'h23, bcd(w), 8'h10, 8'h05, 8'h24);
      osc(DIV);
      rd(3'd3, d); check("R6 dow", d, bcd((w == 7) ? 1 : w + 1));
    end

    // R5 month ends across leap and common years
    for (int yi = 0; yi < 4; yi++) begin
      for (int m = 1; m <= 12; m++) begin
        int last;
        last = month_len(m, yrs[yi]);
        set_all(8'h59, 8'h59, 8'h23, 8'h01, bcd(last - 1), bcd(m), bcd(yrs[yi]));
        osc(DIV);
        rd(3'd4, d); check("R5 date to last", d, bcd(last));
        set_all(8'h59, 8'h59, 8'h23, 8'h01, bcd(last), bcd(m), bcd(yrs[yi]));
        osc(DIV);
        rd(3'd4, d); check("R5 date wrap", d, 8'h01);
        rd(3'd5, d); check("R5 month", d, bcd((m == 12) ? 1 : m + 1));
        rd(3'd6, d); check("R5 year", d, (m == 12) ? bcd((yrs[yi] + 1) % 100) : bcd(yrs[yi]));
      end
    end

    // R7 field masks
    wr(3'd3, 8'hFD); rd(3'd3, d); check("R7 dow mask", d, 8'h05);
    wr(3'd5, 8'hE9); rd(3'd5, d); check("R7 month mask", d, 8'h09);
    wr(3'd4, 8'hC7); rd(3'd4, d); check("R7 date mask", d, 8'h07);
    wr(3'd2, 8'h95); rd(3'd2, d); check("R7 hour mask", d, 8'h15);
    wr(3'd1, 8'h83); rd(3'd1, d); check("R7 min mask", d, 8'h03);
    wr(3'd0, 8'hA5); rd(3'd0, d); check("R7 sec mask", d, 8'h25);

    // R8 seconds write restarts the divider mid-period
    set_all(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    osc(2);
    wr(3'd0, 8'h10);
    osc(DIV - 1);
    rd(3'd0, d); check("R8 no early tick", d, 8'h10);
    osc(1);
    rd(3'd0, d); check("R8 tick after restart", d, 8'h11);

    // R9 square wave shape and tick rate
    wr(3'd0, 8'h20);
    @(negedge clk);
    osc_tick = 1'b1;
    check("R9 square k0", {7'd0, one_hz_out}, 8'h01);
    for (int k = 1; k < 2 * DIV; k++) begin
      @(negedge clk);
      check("R9 square", {7'd0, one_hz_out}, ((k % DIV) < DIV / 2) ? 8'h01 : 8'h00);
    end
    @(negedge clk);
    osc_tick = 1'b0;
    rd(3'd0, d); check("R9 two ticks", d, 8'h22);

    // R10 user copy frozen while live time runs
    wr(3'd0, 8'h30);
    rd(3'd0, d); check("R10 copy", d, 8'h30);
    osc(2 * DIV);
    @(negedge clk);
    check("R10 frozen", rd_data, 8'h30);
    rd(3'd0, d); check("R10 new copy", d, 8'h32);
    rd(3'd7, d); check("R10 unused address", d, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule